// File: doc/BRIEF.md
# Ping-pong tile transpose buffer

This block takes an image as a stream of pixel rows and returns it in column order, one band of rows at a time. A band (a tile) is a fixed number of consecutive rows. The block collects the band in an on-chip memory bank, then streams it out as column segments. Each segment holds the pixels of one column, top to bottom, across the band. A memory writer downstream can place each segment with a single linear burst.

There are two memory banks. While the output side reads one complete tile, the input side fills the other. The transposition happens on the way in: each incoming pixel is written at the address its column-major position calls for. The read side then only walks addresses in ascending order.

The input is a valid/ready pixel stream with an end-of-row marker. The output is a valid/ready pixel stream that carries three markers: end of segment, start of tile, and end of frame. The default geometry is small (16-pixel rows, 5-row tiles, 235-row frames) so that the memories stay small. A full-size instance sets the parameters to 160, 50 and 2350.

Top module: `ptile_transpose`

## Requirements
- R1: After reset, `out_valid` is 0 and `in_ready` is 1.
- R2: Within each tile, output pixel number k (counting from 0) is the input pixel at tile row k mod TILE_ROWS and column k div TILE_ROWS. Tiles leave in the order they arrived.
- R3: `out_eos` is 1 exactly on the output pixels that come from tile row TILE_ROWS-1, so it marks the last pixel of each column segment.
- R4: `out_sot` is 1 exactly on the first output pixel of each tile.
- R5: A frame holds FRAME_ROWS/TILE_ROWS tiles. `out_eof` is 1 only on the final output pixel of the last tile of a frame, and that pixel also carries `out_eos`. After that tile, the row and tile counts start again, so the next frame is transposed in the same way.
- R6: When both banks hold tiles that have not yet been read out, `in_ready` is 0. With `out_ready` held at 0, exactly 2*ROW_PIX*TILE_ROWS input pixels are accepted and then `in_ready` stays at 0. No accepted pixel is lost or overwritten.
- R7: While `out_valid` is 1 and `out_ready` is 0, the output pixel and its markers stay unchanged. Under any pattern of `out_ready` and `in_valid`, every pixel arrives once and in R2 order.
- R8: One bank fills while the other drains. With both streams always ready, a whole frame is emitted within TILES*(ROW_PIX*TILE_ROWS+6)+ROW_PIX*TILE_ROWS+50 cycles.
- R9: An input row ends on the pixel that carries `in_eol`, or after ROW_PIX pixels if no marker comes. A stream with no `in_eol` at all is transposed the same way as one with a marker on every ROW_PIX-th pixel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_data | input | W | Input pixel |
| in_valid | input | 1 | Input pixel present |
| in_eol | input | 1 | Input pixel is the last of its row |
| in_ready | output | 1 | Block accepts an input pixel |
| out_data | output | W | Output pixel |
| out_valid | output | 1 | Output pixel present |
| out_ready | input | 1 | Consumer takes the output pixel |
| out_eos | output | 1 | Last pixel of a column segment |
| out_sot | output | 1 | First pixel of a tile |
| out_eof | output | 1 | Last pixel of a frame |

## Verification
Filling one bank and draining the other can happen in the same cycle. The most delicate point is the cycle in which the fill bank completes while the drain bank is still releasing its final pixel. The bench provokes this with both streams held ready, so that the two bank pointers turn within a few cycles of each other. It also does so under pseudo-random gaps on both sides, and with the output held off until both banks are full. Every output pixel is judged against the column-major position computed from the input index, and the number of pixels accepted while the output is held off must equal exactly two tiles.

// File: rtl/ptile_transpose.sv
module ptile_transpose #(
  parameter int W          = 16,
  parameter int ROW_PIX    = 16,
  parameter int TILE_ROWS  = 5,
  parameter int FRAME_ROWS = 235
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] in_data,
  input  logic         in_valid,
  input  logic         in_eol,
  output logic         in_ready,
  output logic [W-1:0] out_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic         out_eos,
  output logic         out_sot,
  output logic         out_eof
);
  localparam int DEPTH = ROW_PIX * TILE_ROWS;
  localparam int TILES = FRAME_ROWS / TILE_ROWS;
  localparam int AW    = $clog2(DEPTH);
  localparam int CW    = $clog2(ROW_PIX);
  localparam int RW    = $clog2(TILE_ROWS);
  localparam int TW    = $clog2(TILES);
  localparam int EW    = W + 3;

  logic [W-1:0] mem0 [DEPTH];
  logic [W-1:0] mem1 [DEPTH];

  logic [1:0]    full, lastt;
  logic          wb, rb;
  logic [CW-1:0] c;
  logic [RW-1:0] r;
  logic [TW-1:0] t;
  logic [AW-1:0] ra;
  logic [RW-1:0] k;
  logic          p;
  logic [2:0]    pf;
  logic [W-1:0]  rdq;
  logic [EW-1:0] q0, q1;
  logic [1:0]    cnt;

  logic          acc, eor, rlast, tlast, alast, klast, rd_go, pop, push;
  logic [AW-1:0] waddr;
  logic [EW-1:0] ent;

  assign in_ready = !full[wb];
  assign acc      = in_valid && in_ready;
  assign eor      = in_eol || (c == CW'(ROW_PIX - 1));
  assign rlast    = (r == RW'(TILE_ROWS - 1));
  assign tlast    = (t == TW'(TILES - 1));
  assign waddr    = AW'(int'(c) * TILE_ROWS + int'(r));

  assign alast    = (ra == AW'(DEPTH - 1));
  assign klast    = (k == RW'(TILE_ROWS - 1));
  assign out_valid = (cnt != 2'd0);
  assign {out_eof, out_sot, out_eos, out_data} = q0;
  assign pop      = out_valid && out_ready;
  assign push     = p;
  assign ent      = {pf, rdq};
  assign rd_go    = full[rb] && ({1'b0, cnt} + {2'b0, p} < 3'd2 + {2'b0, pop});

  always_ff @(posedge clk) begin
    if (acc) begin
      if (wb) mem1[waddr] <= in_data;
      else    mem0[waddr] <= in_data;
    end
    if (rd_go) rdq <= rb ? mem1[ra] : mem0[ra];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full <= '0; lastt <= '0; wb <= 1'b0; rb <= 1'b0;
      c <= '0; r <= '0; t <= '0; ra <= '0; k <= '0;
      p <= 1'b0; pf <= '0; q0 <= '0; q1 <= '0; cnt <= '0;
    end else begin
      if (acc) begin
        c <= eor ? '0 : c + 1'b1;
        if (eor) begin
          r <= rlast ? '0 : r + 1'b1;
          if (rlast) begin
            full[wb]  <= 1'b1;
            lastt[wb] <= tlast;
            wb        <= ~wb;
            t         <= tlast ? '0 : t + 1'b1;
          end
        end
      end
      if (rd_go) begin
        ra <= alast ? '0 : ra + 1'b1;
        k  <= klast ? '0 : k + 1'b1;
        if (alast) begin
          full[rb] <= 1'b0;
          rb       <= ~rb;
        end
      end
      p  <= rd_go;
      pf <= {alast && lastt[rb], ra == '0, klast};
      case ({push, pop})
        2'b10: begin
          if (cnt == 2'd0) q0 <= ent; else q1 <= ent;
          cnt <= cnt + 1'b1;
        end
        2'b01: begin
          q0  <= q1;
          cnt <= cnt - 1'b1;
        end
        2'b11: begin
          if (cnt == 2'd1) q0 <= ent;
          else begin q0 <= q1; q1 <= ent; end
        end
        default: ;
      endcase
    end
  end

  // R6
  stall_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |-> full[rb]);

  // R7
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable({out_eof, out_sot, out_eos, out_data}));

  // R7
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push && cnt == 2'd2 |-> pop);

  // R5
  eof_seg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_eof |-> out_eos);
endmodule

// File: tb/sim_ptile_transpose.sv
module sim_ptile_transpose;
  localparam int CLK_PERIOD = 10;
  localparam int W     = 16;
  localparam int ROW   = 16;
  localparam int TH    = 5;
  localparam int FR    = 235;
  localparam int DEPTH = ROW * TH;
  localparam int TILES = FR / TH;
  localparam int FPIX  = TILES * DEPTH;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [W-1:0] in_data = '0;
  logic in_valid = 1'b0, in_eol = 1'b0, out_ready = 1'b0;
  logic in_ready, out_valid, out_eos, out_sot, out_eof;
  logic [W-1:0] out_data;

  int n_chk = 0, n_fail = 0;
  int e_dat, e_eos, e_sot, e_eof, n_eof, acc_h, cyc_done;
  logic rdy_h;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  ptile_transpose #(.W(W), .ROW_PIX(ROW), .TILE_ROWS(TH), .FRAME_ROWS(FR)) u0 (
    .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_valid(in_valid), .in_eol(in_eol),
    .in_ready(in_ready), .out_data(out_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_eos(out_eos), .out_sot(out_sot), .out_eof(out_eof));

  function automatic logic [W-1:0] pix(int f, int t, int r, int c);
    return W'(f * 4001 + t * DEPTH + r * ROW + c + 1);
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    in_valid = 1'b0; out_ready = 1'b0; in_eol = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic run(int nfr, bit rmode, bit vmode, bit eolmode, int hold);
    int i = 0, j = 0, cyc = 0;
    int total = nfr * FPIX;
    logic [15:0] lf = 16'hACE1;
    e_dat = 0; e_eos = 0; e_sot = 0; e_eof = 0; n_eof = 0; acc_h = -1; rdy_h = 1'b1;
    cyc_done = -1;
    while (j < total && cyc < 60000) begin
      @(negedge clk);
      out_ready = (cyc < hold) ? 1'b0 : (rmode ? (lf[0] | lf[1]) : 1'b1);
      in_valid  = (i < total) && (vmode ? (lf[2] | lf[4]) : 1'b1);
      begin
        int f = i / FPIX, rem = i % FPIX;
        int t = rem / DEPTH, r = (rem % DEPTH) / ROW, c = rem % ROW;
        in_data = pix(f, t, r, c);
        in_eol  = eolmode && (c == ROW - 1);
      end
      if (cyc == hold - 1) begin acc_h = i; rdy_h = in_ready; end
      if (in_valid && in_ready) i++;
      if (out_valid && out_ready) begin
        int f = j / FPIX, rem = j % FPIX;
        int t = rem / DEPTH, kk = rem % DEPTH;
        int c = kk / TH, r = kk % TH;
        if (out_data !== pix(f, t, r, c)) e_dat++;
        if (out_eos !== (r == TH - 1)) e_eos++;
        if (out_sot !== (kk == 0)) e_sot++;
        if (out_eof !== (t == TILES - 1 && kk == DEPTH - 1)) e_eof++;
        if (out_eof === 1'b1) n_eof++;
        j++;
        if (j == total) cyc_done = cyc + 1;
      end
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      cyc++;
    end
    @(negedge clk);
    in_valid = 1'b0; out_ready = 1'b0;
    check(j == total, "R7 all pixels emitted", j, total);
  endtask

  task automatic t_reset();
    do_reset();
    // R1
    check(out_valid == 1'b0, "R1 out_valid after reset", int'(out_valid), 0);
    check(in_ready == 1'b1, "R1 in_ready after reset", int'(in_ready), 1);
  endtask

  task automatic t_basic();
    do_reset();
    run(1, 1'b0, 1'b0, 1'b1, 0);
    check(e_dat == 0, "R2 transposed order", e_dat, 0);
    check(e_eos == 0, "R3 end-of-segment", e_eos, 0);
    check(e_sot == 0, "R4 start-of-tile", e_sot, 0);
    check(e_eof == 0 && n_eof == 1, "R5 end-of-frame", n_eof, 1);
    check(cyc_done > 0 && cyc_done <= TILES * (DEPTH + 6) + DEPTH + 50,
          "R8 concurrent fill and drain", cyc_done, TILES * (DEPTH + 6) + DEPTH + 50);
  endtask

  task automatic t_random();
    do_reset();
    run(2, 1'b1, 1'b1, 1'b1, 0);
    check(e_dat == 0, "R7 data under random ready", e_dat, 0);
    check(e_eos + e_sot == 0, "R3 R4 markers under random ready", e_eos + e_sot, 0);
    check(e_eof == 0 && n_eof == 2, "R5 second frame restarts", n_eof, 2);
  endtask

  task automatic t_hold();
    do_reset();
    run(1, 1'b0, 1'b0, 1'b1, 400);
    check(acc_h == 2 * DEPTH, "R6 pixels accepted while held", acc_h, 2 * DEPTH);
    check(rdy_h == 1'b0, "R6 in_ready low with both banks full", int'(rdy_h), 0);
    check(e_dat == 0, "R6 no pixel overwritten", e_dat, 0);
  endtask

  task automatic t_noeol();
    do_reset();
    run(1, 1'b1, 1'b0, 1'b0, 0);
    check(e_dat == 0 && e_eos == 0, "R9 rows counted without marker", e_dat, 0);
  endtask

  initial begin
    t_reset();
    t_basic();
    t_random();
    t_hold();
    t_noeol();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 190000, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule